// File: doc/BRIEF.md
# Descriptor Pointer Fetch Queue

This block is the front end of a DMA-style processing channel. Software prepares a descriptor in memory and starts work on it by writing the descriptor's first-byte address to the block's host write port. The address joins a small first-in, first-out pointer queue. Whenever the channel is idle and the queue holds work, the block raises a fetch request that carries the oldest queued address. It holds that request until the bus side signals that the fetch is done.

When the fetch is done, the block moves the pointer into a 64-bit current-descriptor register on the next clock edge and drops it from the queue. Software can read this register but cannot write it. The upper 32 bits of the register are reserved and read as zero. The same stored address is also presented as the target for writing back the modified header dword. While the descriptor is being worked on, the block tracks an 8-bit progress code that downstream processing advances. When downstream processing signals that the descriptor is finished, the channel returns to idle and can take the next pointer.

Top module: `descPtrFetchQueue`

## Requirements
- R1: After reset, `curDescPtr` is 0, `queueEmpty` is 1, `queueFull` is 0, `overflowErr` is 0, `fetchReq` is 0 and `progress` is 0x07.
- R2: Pointers are handed to the fetch side in the order they were written: whenever `fetchReq` is 1, `fetchAddr` equals the oldest pointer still queued.
- R3: The queue holds 8 pointers. `queueEmpty` is 1 when it holds none and `queueFull` is 1 when it holds 8. A host write while `queueFull` is 1 is dropped, even in a cycle that pops an entry. Such a write sets `overflowErr`, which stays at 1 until reset.
- R4: `fetchReq` rises one cycle after the channel is idle with a non-empty queue. Once raised, it stays at 1 with `fetchAddr` unchanged until a cycle in which `fetchDone` is 1. Only one fetch is outstanding at a time.
- R5: In the cycle after `fetchReq` and `fetchDone` are both 1, the low 32 bits of `curDescPtr` hold the fetched pointer and that pointer has left the queue. `curDescPtr` changes at no other time.
- R6: The upper 32 bits (63:32) of `curDescPtr` always read as zero. The block has no port that writes `curDescPtr`.
- R7: `progress` becomes 0x00 when a descriptor is loaded. Each `stageAdv` pulse while a descriptor is loaded raises it by one, up to 0x07, where it saturates. Values 0x03 to 0x06 denote pointer dwords 3 to 6. 0x07 means complete or not begun, and it is the value while idle and after `descFinish`. Values 0x08 and above never appear.
- R8: `wbAddrValid` is 1 exactly while `hdrWbEnable` is 1 and a descriptor is loaded. While it is 1, `wbAddr` equals the low 32 bits of `curDescPtr`; otherwise `wbAddr` is 0. `wbStrobe` is 1 for the single cycle in which `descFinish` ends a loaded descriptor with `hdrWbEnable` at 1. That `descFinish` returns the channel to idle.
- R9: `stageAdv`, `descFinish` and `fetchDone` have no effect while no descriptor is loaded and no fetch is pending. `progress` stays at 0x07 and `curDescPtr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe that pushes a descriptor pointer |
| hostWrData | input | 32 | Descriptor first-byte address to enqueue |
| queueEmpty | output | 1 | Queue holds no pointer |
| queueFull | output | 1 | Queue holds 8 pointers |
| overflowErr | output | 1 | Sticky flag: a write arrived while the queue was full |
| fetchReq | output | 1 | Descriptor fetch request |
| fetchAddr | output | 32 | Address to fetch; meaningful while fetchReq is 1 |
| fetchDone | input | 1 | Fetch completion pulse |
| curDescPtr | output | 64 | Read-only current-descriptor register |
| hdrWbEnable | input | 1 | Header writeback notification enabled |
| wbAddrValid | output | 1 | wbAddr holds a valid writeback target |
| wbAddr | output | 32 | Header writeback address |
| wbStrobe | output | 1 | One-cycle header writeback trigger |
| stageAdv | input | 1 | Downstream advanced to the next descriptor dword |
| descFinish | input | 1 | Downstream finished the loaded descriptor |
| progress | output | 8 | Progress code of the descriptor in flight |

## Verification
A wrong read or write index in the queue shows up as a wrong `fetchAddr` at the next request, or as empty/full flags that disagree with the count of accepted writes. Either appears within one fetch of the fault. A channel state that drifts shows up the same cycle as a `fetchReq` that is missing or premature. It also shows up as `wbAddrValid` at the wrong time, or as a `progress` code that fails to return to 0x07. A load that is missed or doubled shows up on `curDescPtr` one cycle after the `fetchDone` in question. The bench runs a cycle-level reference model of the queue and channel alongside the design, so any such divergence is reported in the cycle it first appears.

// File: rtl/descq_pkg.sv
`timescale 1ns/1ps
package descq_pkg;

  // Channel phase seen by the control
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_FETCH  = 2'd1,
    CH_ACTIVE = 2'd2
  } chanState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;        // accept a host pointer
    logic popLoad;     // pop head and load current register
    logic progAdv;     // step the progress code
    logic progFinish;  // force progress to the done code
    logic ovfSet;      // record a dropped write
  } dpStrobes_t;

  localparam int PROG_DONE_CODE = 7;

endpackage

// File: rtl/descq_fifo.sv
`timescale 1ns/1ps
module descq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [CNT_W-1:0] fillCnt;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wrIdx] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      fillCnt <= '0;
    end else begin
      if (push) wrIdx <= nextIdx(wrIdx);
      if (pop)  rdIdx <= nextIdx(rdIdx);
      case ({push, pop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  assign headData = slots[rdIdx];
  assign empty    = (fillCnt == '0);
  assign full     = (fillCnt == FULL_CNT);

  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/descq_ctrl.sv
`timescale 1ns/1ps
module descq_ctrl
  import descq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       qEmpty,
  input  logic       qFull,
  input  logic       fetchDone,
  input  logic       stageAdv,
  input  logic       descFinish,
  input  logic       hdrWbEnable,
  output dpStrobes_t strb,
  output logic       fetchReq,
  output logic       descActive,
  output logic       wbStrobe
);

  chanState_e state;
  chanState_e stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      CH_IDLE:   if (!qEmpty)    stateNxt = CH_FETCH;
      CH_FETCH:  if (fetchDone)  stateNxt = CH_ACTIVE;
      CH_ACTIVE: if (descFinish) stateNxt = CH_IDLE;
      default:                   stateNxt = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CH_IDLE;
    else       state <= stateNxt;
  end

  assign fetchReq   = (state == CH_FETCH);
  assign descActive = (state == CH_ACTIVE);

  always_comb begin
    strb            = '0;
    strb.push       = hostWrEn && !qFull;
    strb.ovfSet     = hostWrEn && qFull;
    strb.popLoad    = fetchReq && fetchDone;
    strb.progFinish = descActive && descFinish;
    strb.progAdv    = descActive && stageAdv && !descFinish;
  end

  assign wbStrobe = descActive && descFinish && hdrWbEnable;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchDone |=> fetchReq);

  // R5
  load_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descActive) |-> $past(fetchReq && fetchDone));

  // R8
  finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    descActive && descFinish |=> !descActive);

  // R4
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fetchReq, descActive}));

endmodule

// File: rtl/descq_dp.sv
`timescale 1ns/1ps
module descq_dp
  import descq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int PROG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [ADDR_W-1:0] hostWrData,
  output logic              qEmpty,
  output logic              qFull,
  output logic [ADDR_W-1:0] headPtr,
  output logic [ADDR_W-1:0] curPtr,
  output logic [PROG_W-1:0] progress,
  output logic              overflowErr
);

  localparam logic [PROG_W-1:0] DONE_CODE = PROG_W'(PROG_DONE_CODE);

  descq_fifo #(
    .WIDTH (ADDR_W),
    .DEPTH (DEPTH)
  ) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.push),
    .pushData (hostWrData),
    .pop      (strb.popLoad),
    .headData (headPtr),
    .empty    (qEmpty),
    .full     (qFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             curPtr <= '0;
    else if (strb.popLoad) curPtr <= headPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                progress <= DONE_CODE;
    else if (strb.popLoad)    progress <= '0;
    else if (strb.progFinish) progress <= DONE_CODE;
    else if (strb.progAdv && progress != DONE_CODE)
                              progress <= progress + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overflowErr <= 1'b0;
    else if (strb.ovfSet) overflowErr <= 1'b1;
  end

  // R5
  cur_only_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curPtr) |-> $past(strb.popLoad));

  // R7
  prog_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    progress <= DONE_CODE);

  // R7
  prog_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.popLoad) |-> progress == '0);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(overflowErr) |-> overflowErr);

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ovfSet) |-> overflowErr);

endmodule

// File: rtl/descPtrFetchQueue.sv
`timescale 1ns/1ps
module descPtrFetchQueue
  import descq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64,
  parameter int DEPTH  = 8,
  parameter int PROG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrData,
  output logic              queueEmpty,
  output logic              queueFull,
  output logic              overflowErr,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchDone,
  output logic [REG_W-1:0]  curDescPtr,
  input  logic              hdrWbEnable,
  output logic              wbAddrValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              wbStrobe,
  input  logic              stageAdv,
  input  logic              descFinish,
  output logic [PROG_W-1:0] progress
);

  localparam int RSV_W = REG_W - ADDR_W;

  dpStrobes_t        strb;
  logic              descActive;
  logic [ADDR_W-1:0] curPtr;

  descq_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostWrEn    (hostWrEn),
    .qEmpty      (queueEmpty),
    .qFull       (queueFull),
    .fetchDone   (fetchDone),
    .stageAdv    (stageAdv),
    .descFinish  (descFinish),
    .hdrWbEnable (hdrWbEnable),
    .strb        (strb),
    .fetchReq    (fetchReq),
    .descActive  (descActive),
    .wbStrobe    (wbStrobe)
  );

  descq_dp #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .PROG_W (PROG_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hostWrData  (hostWrData),
    .qEmpty      (queueEmpty),
    .qFull       (queueFull),
    .headPtr     (fetchAddr),
    .curPtr      (curPtr),
    .progress    (progress),
    .overflowErr (overflowErr)
  );

  assign curDescPtr  = {{RSV_W{1'b0}}, curPtr};
  assign wbAddrValid = hdrWbEnable && descActive;
  assign wbAddr      = wbAddrValid ? curPtr : '0;

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchDone |=> $stable(fetchAddr));

  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbStrobe |=> !wbStrobe);

  // R8
  wb_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbStrobe |-> wbAddrValid && wbAddr == curDescPtr[ADDR_W-1:0]);

endmodule

// File: tb/test_descPtrFetchQueue.sv
`timescale 1ns/1ps
module test_descPtrFetchQueue;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic        fetchDone = 1'b0;
  logic        hdrWbEnable = 1'b0;
  logic        stageAdv = 1'b0;
  logic        descFinish = 1'b0;
  logic        queueEmpty, queueFull, overflowErr, fetchReq;
  logic [31:0] fetchAddr, wbAddr;
  logic [63:0] curDescPtr;
  logic        wbAddrValid, wbStrobe;
  logic [7:0]  progress;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] mQ[$];
  int          mState = 0;   // 0 idle, 1 fetch, 2 active
  logic [31:0] mCur = '0;
  int          mProg = 7;
  bit          mOvf = 1'b0;

  always #5 clk = ~clk;

  descPtrFetchQueue i_descPtrFetchQueue (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .queueEmpty(queueEmpty), .queueFull(queueFull), .overflowErr(overflowErr),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchDone(fetchDone),
    .curDescPtr(curDescPtr), .hdrWbEnable(hdrWbEnable),
    .wbAddrValid(wbAddrValid), .wbAddr(wbAddr), .wbStrobe(wbStrobe),
    .stageAdv(stageAdv), .descFinish(descFinish), .progress(progress)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWbAddr(input bit hwb);
    return (hwb && mState == 2) ? mCur : 32'h0;
  endfunction

  // one clock cycle: drive, compare against model, advance model
  task automatic step(input bit wr, input logic [31:0] d, input bit dn,
                      input bit adv, input bit fin, input bit hwb);
    int sz;
    bit fullOld;
    bit popv;
    @(negedge clk);
    hostWrEn = wr; hostWrData = d; fetchDone = dn;
    stageAdv = adv; descFinish = fin; hdrWbEnable = hwb;
    #1;
    sz = mQ.size();
    chk("R3 empty", 64'(queueEmpty), 64'(sz == 0));
    chk("R3 full", 64'(queueFull), 64'(sz == 8));
    chk("R3 overflow", 64'(overflowErr), 64'(mOvf));
    chk("R4 fetchReq", 64'(fetchReq), 64'(mState == 1));
    if (mState == 1) chk("R2 fetchAddr order", 64'(fetchAddr), 64'(mQ[0]));
    chk("R5 curDescPtr", curDescPtr, {32'h0, mCur});
    chk("R6 reserved bits", 64'(curDescPtr[63:32]), 64'h0);
    chk("R7 progress", 64'(progress), 64'(mProg));
    chk("R8 wbAddrValid", 64'(wbAddrValid), 64'(hwb && mState == 2));
    chk("R8 wbAddr", 64'(wbAddr), 64'(expWbAddr(hwb)));
    chk("R8 wbStrobe", 64'(wbStrobe), 64'(hwb && fin && mState == 2));
    fullOld = (sz == 8);
    popv = 1'b0;
    if (wr && fullOld) mOvf = 1'b1;
    case (mState)
      0: if (sz > 0) mState = 1;
      1: if (dn) begin mCur = mQ[0]; popv = 1'b1; mProg = 0; mState = 2; end
      default: begin
        if (fin) begin mProg = 7; mState = 0; end
        else if (adv && mProg < 7) mProg++;
      end
    endcase
    if (popv) void'(mQ.pop_front());
    if (wr && !fullOld) mQ.push_back(d);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] firstPtr;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 curDescPtr", curDescPtr, 64'h0);
    chk("R1 empty", 64'(queueEmpty), 64'h1);
    chk("R1 full", 64'(queueFull), 64'h0);
    chk("R1 overflow", 64'(overflowErr), 64'h0);
    chk("R1 fetchReq", 64'(fetchReq), 64'h0);
    chk("R1 progress", 64'(progress), 64'h07);

    // R9: strobes while idle and empty have no effect
    step(0, 0, 1, 1, 1, 1);
    step(0, 0, 1, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R9 progress idle", 64'(progress), 64'h07);
    chk("R9 curDescPtr idle", curDescPtr, 64'h0);
    chk("R9 no wbStrobe", 64'(wbStrobe), 64'h0);

    // R3: fill beyond depth without completing the fetch
    firstPtr = 32'h1000_0040;
    for (int i = 0; i < 10; i++) step(1, firstPtr + 32'(i * 64), 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R3 full after 10 writes", 64'(queueFull), 64'h1);
    chk("R3 overflow sticky", 64'(overflowErr), 64'h1);
    chk("R4 fetchAddr held", 64'(fetchAddr), 64'(firstPtr));

    // R3: write while full and popping is still dropped
    step(1, 32'hDEAD_0000, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R5 loaded first pointer", curDescPtr, {32'h0, firstPtr});
    chk("R3 drop during pop", 64'(queueFull), 64'h0);

    // R7: advance past the last code, saturate
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R7 saturate", 64'(progress), 64'h07);
    chk("R8 wbAddr while loaded", 64'(wbAddr), 64'(firstPtr));
    step(0, 0, 0, 0, 1, 1);   // wbStrobe checked in step
    step(0, 0, 0, 0, 0, 1);
    chk("R8 back to idle", 64'(wbAddrValid), 64'h0);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int wp;
      wp = (i < 2000) ? 40 : ((i < 4000) ? 85 : 15);
      step(($urandom % 100) < wp, $urandom, ($urandom % 4) == 0,
           ($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 10) < 7);
    end
    // drain
    for (int i = 0; i < 200; i++) step(0, 0, 1, 1, 1, 1);
    chk("R2 drained", 64'(queueEmpty), 64'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule